// File: doc/BRIEF.md
# Flash Byte Program-Verify Sequencer

This block writes a single byte into a parallel NOR-style flash part. It does not rely on one write strobe. It runs a closed loop: it issues a program command, holds a timed program pulse, issues a verify command, waits for the read path to settle, and compares the byte read back with the intended value. It repeats this loop until the byte matches or a hard limit on the number of pulses is reached.

A caller presents an address and a data byte together with a one-cycle start request. The sequencer latches both and owns the flash bus until it finishes. It then reports success or failure with a one-cycle strobe, and a count output shows how many program pulses the byte needed. An abort request ends a running operation by writing the all-ones reset code to the flash twice. The sequencer then returns to idle and never drives the caller's byte again.

The pulse length is given in nanoseconds and converted to clock cycles from the clock frequency parameter. The settling delay and the pulse limit are parameters counted in cycles and attempts. The setup and verify command codes are also parameters.

Top module: `flash_pv_ctrl`

## Requirements
- R1: While reset is held and in the first idle cycle after it, the write strobe, read enable, programming-voltage enable, done and fail outputs are low and the pulse count reads zero.
- R2: Each attempt writes the setup code (default 40h) and then the latched data byte to the latched address in two consecutive cycles. The bus then stays quiet for exactly PULSE_CYC cycles, where PULSE_CYC = ceil(PULSE_NS * CLK_KHZ / 10^6). After that the verify code (default C0h) is written for one cycle.
- R3: Read enable is asserted only after a verify write, for SETTLE_CYC + 1 consecutive cycles starting in the cycle after it. The read-back byte is compared in the last of these cycles only.
- R4: A matching read-back ends the operation. Done is high for exactly one cycle, in the cycle after the compare, and the bus goes idle.
- R5: A mismatching read-back, with fewer than MAX_PULSES pulses spent, starts a new attempt with the setup write in the very next cycle. No second pulse is ever issued without a verify in between.
- R6: After the MAX_PULSES-th pulse (default 25) fails its verify, fail is high for exactly one cycle, the pulse count equals MAX_PULSES, and no further bus writes occur.
- R7: The pulse count clears when a start is accepted, equals the number of data-byte writes made for that byte, and holds until the next accepted start.
- R8: The programming-voltage enable is high in every cycle in which the bus is written or read during an operation, including the abort writes. It is low whenever the block is idle.
- R9: An abort seen while busy produces exactly two bus writes of FFh to the latched address, in the two cycles after the abort is sampled. It produces no data-byte write afterwards and no done or fail, and it leaves the block idle.
- R10: An abort sampled in the same cycle as the read-back compare takes priority: the result is discarded and the abort sequence of R9 runs.
- R11: A start request while busy is ignored, and the latched address and data do not change. An abort request while idle is ignored and causes no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| abort_i | input | 1 | Abort request, sampled when busy |
| addr_i | input | ADDR_W | Target byte address |
| data_i | input | DATA_W | Byte to program |
| flash_addr_o | output | ADDR_W | Flash address bus |
| flash_wdata_o | output | DATA_W | Flash write data bus |
| flash_we_o | output | 1 | Flash write strobe, active high |
| flash_oe_o | output | 1 | Flash read enable, active high |
| vpp_en_o | output | 1 | Programming-voltage enable |
| flash_rdata_i | input | DATA_W | Flash read data |
| done_o | output | 1 | One-cycle success strobe |
| fail_o | output | 1 | One-cycle failure strobe |
| pulses_o | output | CNT_W | Program pulses used for the last byte |

## Verification
The read-back compare and an abort request can land in the same cycle. The bench provokes this by having the flash model return the correct byte on the first verify. It then asserts abort exactly SETTLE_CYC + 1 cycles after it observes the verify write, which is the compare cycle. The outcome is judged at the ports: no done or fail strobe may appear, exactly two FFh writes must follow, and the block must accept the next start normally. The flash model also returns a wrong byte before the settling time has elapsed, so a compare taken one cycle early shows up as an extra pulse or a failure.

// File: rtl/flash_pv_pkg.sv
// Shared types and helpers for the flash program-verify sequencer.
// Assumes: clock frequency given in kHz, pulse length in ns.
package flash_pv_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_DATA,
        ST_PULSE,
        ST_VCMD,
        ST_SETTLE,
        ST_SAMPLE,
        ST_ABORT1,
        ST_ABORT2
    } pv_state_e;

    // Converts a duration in ns to clock cycles, rounded up, at least 1.
    function automatic int ns_to_cycles(input int ns, input int khz);
        longint prod;
        longint cyc;
        prod = longint'(ns) * longint'(khz);
        cyc  = (prod + 64'sd999999) / 64'sd1000000;
        if (cyc < 1) cyc = 1;
        return int'(cyc);
    endfunction

endpackage

// File: rtl/flash_pv_timer.sv
// Wait-state cycle counter shared by the program pulse and the settle delay.
// Counts only while enabled; clears whenever the controller changes state.
// Assumes: limit_i >= 1 and constant during one enabled interval.
module flash_pv_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          clr_i,
    input  logic [TW-1:0] limit_i,
    output logic          expire_o
);

    logic [TW-1:0] cnt_q;

    // Counts enabled cycles of the current wait state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flags the last cycle of the wait interval.
    always_comb begin
        expire_o = en_i && (cnt_q == limit_i - 1'b1);
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (cnt_q < limit_i)); // R2

endmodule

// File: rtl/flash_pv_attempts.sv
// Counts program pulses applied to the current byte and flags the limit.
// Assumes: inc_i is never raised once the limit has been reached.
module flash_pv_attempts #(
    parameter int MAXP = 25,
    parameter int CW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] count_o,
    output logic          last_o
);

    logic [CW-1:0] count_q;

    // Clears on an accepted start, advances on each data-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (inc_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Exposes the count and the limit flag.
    always_comb begin
        count_o = count_q;
        last_o  = (count_q == CW'(MAXP));
    end

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(MAXP)); // R6
    AST_INC_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> (count_q < CW'(MAXP))); // R5

endmodule

// File: rtl/flash_pv_busdrv.sv
// Decodes the controller state into flash bus controls and write data.
// Assumes: the abort reset code is all ones.
module flash_pv_busdrv
    import flash_pv_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] SETUP_CMD  = 8'h40,
    parameter logic [DATA_W-1:0] VERIFY_CMD = 8'hC0
) (
    input  pv_state_e         state_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              we_o,
    output logic              oe_o,
    output logic              vpp_o,
    output logic [DATA_W-1:0] wdata_o
);

    // Selects strobe, read enable and write data per state.
    always_comb begin
        we_o    = 1'b0;
        oe_o    = 1'b0;
        wdata_o = '0;
        unique case (state_i)
            ST_SETUP:  begin we_o = 1'b1; wdata_o = SETUP_CMD;  end
            ST_DATA:   begin we_o = 1'b1; wdata_o = data_i;     end
            ST_VCMD:   begin we_o = 1'b1; wdata_o = VERIFY_CMD; end
            ST_ABORT1,
            ST_ABORT2: begin we_o = 1'b1; wdata_o = '1;         end
            ST_SETTLE,
            ST_SAMPLE: oe_o = 1'b1;
            default:   ;
        endcase
    end

    // Holds the programming voltage on for every non-idle state.
    always_comb begin
        vpp_o = (state_i != ST_IDLE);
    end

endmodule

// File: rtl/flash_pv_ctrl.sv
// Flash byte program-verify sequencer (top).
// Runs setup / data / timed pulse / verify / settle / compare attempts until
// the byte reads back correctly or MAX_PULSES pulses are spent; an abort while
// busy writes the reset code twice and returns to idle.
// Assumes: SETTLE_CYC >= 1; flash read data is valid SETTLE_CYC cycles after
// the verify write; synchronous active-low reset.
module flash_pv_ctrl
    import flash_pv_pkg::*;
#(
    parameter int                ADDR_W     = 18,
    parameter int                DATA_W     = 8,
    parameter int                CLK_KHZ    = 200000,
    parameter int                PULSE_NS   = 10000,
    parameter int                SETTLE_CYC = 4,
    parameter int                MAX_PULSES = 25,
    parameter int                CNT_W      = $clog2(MAX_PULSES + 1),
    parameter logic [DATA_W-1:0] SETUP_CMD  = 8'h40,
    parameter logic [DATA_W-1:0] VERIFY_CMD = 8'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ADDR_W-1:0] flash_addr_o,
    output logic [DATA_W-1:0] flash_wdata_o,
    output logic              flash_we_o,
    output logic              flash_oe_o,
    output logic              vpp_en_o,
    input  logic [DATA_W-1:0] flash_rdata_i,
    output logic              done_o,
    output logic              fail_o,
    output logic [CNT_W-1:0]  pulses_o
);

    localparam int PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_KHZ);
    localparam int WAIT_MAX  = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
    localparam int TW        = $clog2(WAIT_MAX + 1);

    pv_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              done_q, fail_q;
    logic              busy, in_abort, accept, match;
    logic              tmr_en, tmr_clr, tmr_exp;
    logic [TW-1:0]     tmr_lim;
    logic              cnt_last;

    // Classifies the current state and the start/compare conditions.
    always_comb begin
        busy     = (state_q != ST_IDLE);
        in_abort = (state_q == ST_ABORT1) || (state_q == ST_ABORT2);
        accept   = (state_q == ST_IDLE) && start_i;
        match    = (flash_rdata_i == data_q);
    end

    // Computes the next sequencer state; abort overrides every busy step.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_DATA;
            ST_DATA:   state_d = ST_PULSE;
            ST_PULSE:  if (tmr_exp) state_d = ST_VCMD;
            ST_VCMD:   state_d = ST_SETTLE;
            ST_SETTLE: if (tmr_exp) state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = (match || cnt_last) ? ST_IDLE : ST_SETUP;
            ST_ABORT1: state_d = ST_ABORT2;
            ST_ABORT2: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (abort_i && busy && !in_abort) state_d = ST_ABORT1;
    end

    // Advances the state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latches the target address and byte on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            addr_q <= addr_i;
            data_q <= data_i;
        end
    end

    // Produces the one-cycle result strobes from the compare cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_SAMPLE) && !abort_i && match;
            fail_q <= (state_q == ST_SAMPLE) && !abort_i && !match && cnt_last;
        end
    end

    // Selects the wait length for the timer.
    always_comb begin
        tmr_en  = (state_q == ST_PULSE) || (state_q == ST_SETTLE);
        tmr_clr = (state_d != state_q);
        tmr_lim = (state_q == ST_PULSE) ? TW'(PULSE_CYC) : TW'(SETTLE_CYC);
    end

    flash_pv_timer #(
        .TW (TW)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (tmr_en),
        .clr_i    (tmr_clr),
        .limit_i  (tmr_lim),
        .expire_o (tmr_exp)
    );

    flash_pv_attempts #(
        .MAXP (MAX_PULSES),
        .CW   (CNT_W)
    ) attempts_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .inc_i   (state_q == ST_DATA),
        .count_o (pulses_o),
        .last_o  (cnt_last)
    );

    flash_pv_busdrv #(
        .DATA_W     (DATA_W),
        .SETUP_CMD  (SETUP_CMD),
        .VERIFY_CMD (VERIFY_CMD)
    ) busdrv_i (
        .state_i (state_q),
        .data_i  (data_q),
        .we_o    (flash_we_o),
        .oe_o    (flash_oe_o),
        .vpp_o   (vpp_en_o),
        .wdata_o (flash_wdata_o)
    );

    // Drives the result and address outputs.
    always_comb begin
        flash_addr_o = addr_q;
        done_o       = done_q;
        fail_o       = fail_q;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4
    AST_FAIL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> !fail_o); // R6
    AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (pulses_o == CNT_W'(MAX_PULSES))); // R6
    AST_VPP_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_we_o || flash_oe_o) |-> vpp_en_o); // R8
    AST_ABORT_WRITES_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && busy && !in_abort) |=> (flash_we_o && (flash_wdata_o == '1))); // R9
    AST_ABORT_BEATS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && (state_q == ST_SAMPLE)) |=> (!done_o && !fail_o)); // R10
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(flash_addr_o)); // R11

endmodule

// File: tb/flash_pv_ctrl_tb.sv
`timescale 1ns/1ps
module flash_pv_ctrl_tb_top;

    localparam int AW       = 18;
    localparam int KHZ      = 200000;
    localparam int PNS      = 40;
    localparam int PC       = 8;     // ceil(40 * 200000 / 1e6)
    localparam int SC       = 3;
    localparam int MAXP     = 25;
    localparam int CW       = 5;
    localparam logic [7:0] C_SETUP  = 8'h40;
    localparam logic [7:0] C_VERIFY = 8'hC0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          abort = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [7:0]    data_in = '0;
    logic [AW-1:0] f_addr;
    logic [7:0]    f_wdata;
    logic          f_we, f_oe, vpp;
    logic [7:0]    f_rdata;
    logic          done, fail;
    logic [CW-1:0] pulses;

    int checks = 0, fails = 0, cyc = 0;
    logic [AW-1:0] cur_addr;
    logic [7:0]    cur_data;
    int model_need = 1, model_vseen = 0, ver_age = 0;
    int phase = 0, data_writes = 0, oe_run = 0, writes_total = 0;
    int abort_pending = 0, done_cnt = 0, fail_cnt = 0, last_w = 0;
    bit aborted = 0;

    always #2.5 clk = ~clk;

    flash_pv_ctrl #(
        .ADDR_W(AW), .DATA_W(8), .CLK_KHZ(KHZ), .PULSE_NS(PNS),
        .SETTLE_CYC(SC), .MAX_PULSES(MAXP), .CNT_W(CW),
        .SETUP_CMD(C_SETUP), .VERIFY_CMD(C_VERIFY)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
        .addr_i(addr_in), .data_i(data_in),
        .flash_addr_o(f_addr), .flash_wdata_o(f_wdata), .flash_we_o(f_we),
        .flash_oe_o(f_oe), .vpp_en_o(vpp), .flash_rdata_i(f_rdata),
        .done_o(done), .fail_o(fail), .pulses_o(pulses)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_pulses(input int need);
        return (need <= MAXP) ? need : MAXP;
    endfunction

    function automatic bit exp_pass(input int need);
        return need <= MAXP;
    endfunction

    // Flash model: correct byte only after enough verifies and full settling.
    always_comb begin
        if (ver_age < SC + 1)            f_rdata = ~cur_data;
        else if (model_vseen < model_need) f_rdata = cur_data ^ 8'h01;
        else                             f_rdata = cur_data;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Bus monitor: checks write order, timing, read window and voltage enable.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ver_age < 100000) ver_age++;
            if (f_we) begin
                writes_total++;
                chk(f_addr == cur_addr, "R2", "write address", int'(f_addr), int'(cur_addr));
                if (abort_pending > 0) begin
                    chk(f_wdata == 8'hFF, "R9", "abort code", int'(f_wdata), 255);
                    abort_pending--;
                end else if (aborted) begin
                    chk(1'b0, "R9", "write after abort", int'(f_wdata), -1);
                end else begin
                    case (phase)
                        0: begin
                            chk(f_wdata == C_SETUP, "R2", "setup code", int'(f_wdata), int'(C_SETUP));
                            if (data_writes > 0)
                                chk(oe_run == SC + 1, "R5", "read window before retry", oe_run, SC + 1);
                            phase = 1;
                        end
                        1: begin
                            chk(f_wdata == cur_data && cyc == last_w + 1, "R2", "data write",
                                int'(f_wdata), int'(cur_data));
                            data_writes++;
                            phase = 2;
                        end
                        default: begin
                            chk(f_wdata == C_VERIFY, "R2", "verify code", int'(f_wdata), int'(C_VERIFY));
                            chk(cyc - last_w == PC + 1, "R2", "pulse length", cyc - last_w - 1, PC);
                            model_vseen++;
                            ver_age = 0;
                            oe_run = 0;
                            phase = 0;
                        end
                    endcase
                end
                last_w = cyc;
            end
            if (f_oe) begin
                oe_run++;
                if (phase != 0) chk(1'b0, "R3", "read outside verify window", phase, 0);
            end
            if ((f_we || f_oe) && !vpp) chk(1'b0, "R8", "voltage enable off", 0, 1);
            if (done) done_cnt++;
            if (fail) fail_cnt++;
        end
    end

    task automatic begin_op(input logic [AW-1:0] a, input logic [7:0] d, input int need);
        cur_addr = a; cur_data = d; model_need = need; model_vseen = 0;
        phase = 0; data_writes = 0; aborted = 0; abort_pending = 0;
        done_cnt = 0; fail_cnt = 0; oe_run = 0;
        @(posedge clk); #1;
        start = 1'b1; addr_in = a; data_in = d;
        @(posedge clk); #1;
        start = 1'b0; addr_in = ~a; data_in = ~d;
    endtask

    task automatic run_op(input logic [AW-1:0] a, input logic [7:0] d, input int need,
                          input bit busy_start);
        int n;
        int wt;
        begin_op(a, d, need);
        if (busy_start) begin
            repeat (5) @(posedge clk);
            #1 start = 1'b1; addr_in = a ^ 18'h155; data_in = d ^ 8'h5A;
            @(posedge clk); #1 start = 1'b0;
        end
        n = 0;
        while (!(done || fail) && n < 2000) begin
            @(negedge clk); n++;
        end
        chk(done == exp_pass(need), exp_pass(need) ? "R4" : "R6", "result",
            int'(done), int'(exp_pass(need)));
        chk(fail == !exp_pass(need), "R6", "fail strobe", int'(fail), int'(!exp_pass(need)));
        chk(int'(pulses) == exp_pulses(need), "R7", "pulse count", int'(pulses), exp_pulses(need));
        chk(data_writes == exp_pulses(need), busy_start ? "R11" : "R7", "data writes",
            data_writes, exp_pulses(need));
        chk(oe_run == SC + 1, "R3", "final read window", oe_run, SC + 1);
        wt = writes_total;
        @(negedge clk);
        chk(!done && !fail, "R4", "strobe width", int'(done) + int'(fail), 0);
        repeat (3) @(negedge clk);
        chk(writes_total == wt && !vpp && !f_oe, "R6", "bus idle after result",
            writes_total - wt + int'(vpp), 0);
        chk(int'(pulses) == exp_pulses(need), "R7", "count held", int'(pulses), exp_pulses(need));
    endtask

    // mode 0: abort during setup write, 1: during pulse, 2: in compare cycle.
    task automatic run_abort(input logic [AW-1:0] a, input logic [7:0] d, input int mode);
        int exp_dw;
        begin_op(a, d, 1);
        exp_dw = (mode == 0) ? 0 : 1;
        if (mode == 1) repeat (4) @(posedge clk);
        if (mode == 2) begin
            wait (model_vseen == 1);
            repeat (SC + 1) @(posedge clk);
        end
        #1 abort = 1'b1;
        @(posedge clk); #1;
        abort = 1'b0; abort_pending = 2; aborted = 1;
        repeat (6) @(negedge clk);
        chk(abort_pending == 0, "R9", "abort writes remaining", abort_pending, 0);
        chk(done_cnt == 0 && fail_cnt == 0, (mode == 2) ? "R10" : "R9", "strobes after abort",
            done_cnt + fail_cnt, 0);
        chk(data_writes == exp_dw, "R9", "data writes before abort", data_writes, exp_dw);
        chk(!vpp && !f_we && !f_oe, "R8", "idle after abort", int'(vpp), 0);
    endtask

    initial begin
        int wt;
        void'($urandom(32'd20240611));
        cur_addr = '0; cur_data = 8'h00;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!f_we && !f_oe && !vpp && !done && !fail && pulses == 0, "R1", "reset state",
            int'(f_we) + int'(f_oe) + int'(vpp) + int'(done) + int'(fail) + int'(pulses), 0);

        run_op(18'h00001, 8'hA5, 1, 1'b0);
        run_op(18'h3FFFF, 8'h00, 2, 1'b0);
        run_op(18'h12345, 8'hFF, 4, 1'b1);
        run_op(18'h00100, 8'h3C, MAXP, 1'b0);
        run_op(18'h2AAAA, 8'h81, MAXP + 1, 1'b0);

        run_abort(18'h01010, 8'h77, 0);
        run_abort(18'h02020, 8'h66, 1);
        run_abort(18'h03030, 8'h55, 2);
        run_op(18'h04040, 8'h12, 1, 1'b0);

        wt = writes_total;
        @(posedge clk); #1 abort = 1'b1;
        repeat (3) @(posedge clk); #1 abort = 1'b0;
        repeat (3) @(negedge clk);
        chk(writes_total == wt && !vpp, "R11", "abort while idle", writes_total - wt, 0);

        for (int i = 0; i < 14; i++) begin
            int r;
            int need;
            r = int'($urandom % 6);
            need = (r == 5) ? MAXP + 1 + int'($urandom % 3) : r + 1;
            run_op(AW'($urandom), 8'($urandom), need, (i % 4) == 3);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule